// File: doc/BRIEF.md
# DMA Completion Interrupt Router

This block sits between an eight-channel DMA engine and the processor's interrupt controller. Each DMA channel produces a one-cycle completion pulse, and the engine produces a one-cycle error pulse. The router turns these into four kinds of interrupt:

- a shared master interrupt, backed by a per-channel status mask;
- three dedicated lines, each serving a single channel that software picks;
- an error line that stays asserted until software clears it.

Software programs the router through a small word-wide register port. The port has one write strobe, a shared address and a combinational read path. There are four registers:

| Address | Register | Contents |
|---------|----------|----------|
| 0 | control | master enable in bit 0; dedicated-line enables in bits 1 to 3 |
| 1 | routing | one 3-bit channel selector per dedicated line |
| 2 | status | reads the visible master status mask; writing ones clears channels |
| 3 | error | bit 0 shows the pending error; writing a one clears it |

A channel steered to an enabled dedicated line is taken out of the master path. Its completions then bypass the status mask, so they need no clearing. Disabling the line hands the channel back to the master path.

Top module: `dma_irq_router`

## Requirements
- R1: After a synchronous reset every register reads zero at all four addresses and all interrupt outputs are low.
- R2: A completion pulse on a channel that is not steered sets that channel's bit in the status register (address 2, bit n for channel n) at the next clock edge. The bit stays set until it is cleared.
- R3: irq_master_o is high exactly when control bit 0 is set and at least one visible status bit is set.
- R4: Writing address 2 clears each status bit whose data bit is 1 and leaves the others unchanged. A completion on a channel in the same cycle as its clear leaves its bit set.
- R5: Routing register bits [3k+2:3k] select the channel of dedicated line k (k = 0..2, driving irq_ded_o[k]). While control bit k+1 is set, a completion on that channel yields a one-cycle pulse on irq_ded_o[k] in the following cycle. Several lines may pulse together.
- R6: A channel selected by an enabled dedicated line is hidden from the master path in three ways. Its completions set no status bit. Any status bit it already holds reads as zero and does not raise irq_master_o. Clears written to it are ignored.
- R7: A dedicated line whose control bit is clear produces no pulses, and its selected channel is handled by the master path as if unrouted.
- R8: An error pulse sets the error flag (address 3, bit 0), which drives irq_err_o. The flag holds until a write of 1 to address 3 bit 0. An error pulse in the same cycle as that clear keeps the flag set.
- R9: Completions on several channels in the same cycle each set their own status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| done_i | input | 8 | Per-channel completion pulses |
| err_i | input | 1 | DMA error pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for read and write |
| wr_data_i | input | 16 | Register write data |
| rd_data_o | output | 16 | Register read data for addr_i |
| irq_master_o | output | 1 | Master interrupt |
| irq_ded_o | output | 3 | Dedicated single-channel interrupts |
| irq_err_o | output | 1 | Error interrupt |

## Verification
Completions are applied in several patterns, and each pattern separates one class of fault:

- **Single channels:** show that the right status bit is set.
- **Two channels in one cycle:** show that bits accumulate rather than overwrite.
- **A completion in the same cycle as its clear:** settles set-over-clear priority.
- **Routed channels with their line enabled and then disabled:** separate steering from plain masking.
- **A channel that is steered away while its status bit is set, then cleared, then restored:** proves that clears to steered channels are dropped, not applied.
- **Error pulses alone and together with a clear:** cover the sticky error flag.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 2'd0,
        REG_ROUTE = 2'd1,
        REG_STAT  = 2'd2,
        REG_ERR   = 2'd3
    } reg_addr_e;

    // Write strobe qualified by target register.
    function automatic logic hit(input logic wr_en, input logic [ADDR_W-1:0] addr,
                                 input reg_addr_e target);
        return wr_en && (reg_addr_e'(addr) == target);
    endfunction

endpackage

// File: rtl/dma_irq_cfg.sv
module dma_irq_cfg
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH  = 8,
    parameter int NUM_DED = 3,
    parameter int DATA_W  = 16
) (
    input  logic                           clk_i,
    input  logic                           rst_i,
    input  logic                           wr_en_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [DATA_W-1:0]              wr_data_i,
    output logic                           master_en_o,
    output logic [NUM_DED-1:0]             ded_en_o,
    output logic [NUM_DED*$clog2(NUM_CH)-1:0] route_o,
    output logic [NUM_CH-1:0]              steer_o,
    output logic [DATA_W-1:0]              ctrl_rd_o,
    output logic [DATA_W-1:0]              route_rd_o
);
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int ROUTE_W = NUM_DED * CH_W;
    localparam int CTRL_W  = NUM_DED + 1;

    logic [CTRL_W-1:0]  ctrl_q;
    logic [ROUTE_W-1:0] route_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q  <= '0;
            route_q <= '0;
        end else begin
            if (hit(wr_en_i, addr_i, REG_CTRL))
                ctrl_q <= wr_data_i[CTRL_W-1:0];
            if (hit(wr_en_i, addr_i, REG_ROUTE))
                route_q <= wr_data_i[ROUTE_W-1:0];
        end
    end

    assign master_en_o = ctrl_q[0];
    assign ded_en_o    = ctrl_q[CTRL_W-1:1];
    assign route_o     = route_q;
    assign ctrl_rd_o   = DATA_W'(ctrl_q);
    assign route_rd_o  = DATA_W'(route_q);

    // A channel is steered when any enabled dedicated line selects it.
    always_comb begin
        steer_o = '0;
        for (int k = 0; k < NUM_DED; k++) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (ctrl_q[k+1] && (route_q[k*CH_W +: CH_W] == CH_W'(c)))
                    steer_o[c] = 1'b1;
            end
        end
    end

    logic wr_data_unused;
    assign wr_data_unused = ^wr_data_i;

endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
    parameter int NUM_CH = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [NUM_CH-1:0] done_i,
    input  logic [NUM_CH-1:0] steer_i,
    input  logic              clr_we_i,
    input  logic [NUM_CH-1:0] clr_mask_i,
    output logic [NUM_CH-1:0] status_vis_o
);
    logic [NUM_CH-1:0] status_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        always_ff @(posedge clk_i) begin
            if (rst_i)
                status_q[c] <= 1'b0;
            else if (done_i[c] && !steer_i[c])
                status_q[c] <= 1'b1;
            else if (clr_we_i && clr_mask_i[c] && !steer_i[c])
                status_q[c] <= 1'b0;
        end
    end

    assign status_vis_o = status_q & ~steer_i;

endmodule

// File: rtl/dma_irq_ded.sv
module dma_irq_ded #(
    parameter int NUM_CH  = 8,
    parameter int NUM_DED = 3
) (
    input  logic                              clk_i,
    input  logic                              rst_i,
    input  logic [NUM_CH-1:0]                 done_i,
    input  logic [NUM_DED-1:0]                ded_en_i,
    input  logic [NUM_DED*$clog2(NUM_CH)-1:0] route_i,
    output logic [NUM_DED-1:0]                irq_ded_o
);
    localparam int CH_W = $clog2(NUM_CH);

    for (genvar k = 0; k < NUM_DED; k++) begin : g_line
        logic [CH_W-1:0] sel;
        assign sel = route_i[k*CH_W +: CH_W];
        always_ff @(posedge clk_i) begin
            if (rst_i)
                irq_ded_o[k] <= 1'b0;
            else
                irq_ded_o[k] <= ded_en_i[k] && done_i[sel];
        end
    end

endmodule

// File: rtl/dma_irq_err.sv
module dma_irq_err
    import dma_irq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              err_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              clr_bit_i,
    output logic              err_pend_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i)
            err_pend_o <= 1'b0;
        else if (err_i)
            err_pend_o <= 1'b1;
        else if (hit(wr_en_i, addr_i, REG_ERR) && clr_bit_i)
            err_pend_o <= 1'b0;
    end

endmodule

// File: rtl/dma_irq_router.sv
module dma_irq_router
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH  = 8,
    parameter int NUM_DED = 3,
    parameter int DATA_W  = 16
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_CH-1:0]  done_i,
    input  logic               err_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic               irq_master_o,
    output logic [NUM_DED-1:0] irq_ded_o,
    output logic               irq_err_o
);
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int ROUTE_W = NUM_DED * CH_W;

    logic                master_en;
    logic [NUM_DED-1:0]  ded_en;
    logic [ROUTE_W-1:0]  route;
    logic [NUM_CH-1:0]   steer;
    logic [NUM_CH-1:0]   status_vis;
    logic [DATA_W-1:0]   ctrl_rd;
    logic [DATA_W-1:0]   route_rd;
    logic                err_pend;

    dma_irq_cfg #(.NUM_CH(NUM_CH), .NUM_DED(NUM_DED), .DATA_W(DATA_W)) u_cfg (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .wr_en_i     (wr_en_i),
        .addr_i      (addr_i),
        .wr_data_i   (wr_data_i),
        .master_en_o (master_en),
        .ded_en_o    (ded_en),
        .route_o     (route),
        .steer_o     (steer),
        .ctrl_rd_o   (ctrl_rd),
        .route_rd_o  (route_rd)
    );

    dma_irq_status #(.NUM_CH(NUM_CH)) u_status (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .done_i       (done_i),
        .steer_i      (steer),
        .clr_we_i     (hit(wr_en_i, addr_i, REG_STAT)),
        .clr_mask_i   (wr_data_i[NUM_CH-1:0]),
        .status_vis_o (status_vis)
    );

    dma_irq_ded #(.NUM_CH(NUM_CH), .NUM_DED(NUM_DED)) u_ded (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .done_i    (done_i),
        .ded_en_i  (ded_en),
        .route_i   (route),
        .irq_ded_o (irq_ded_o)
    );

    dma_irq_err u_err (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .err_i      (err_i),
        .wr_en_i    (wr_en_i),
        .addr_i     (addr_i),
        .clr_bit_i  (wr_data_i[0]),
        .err_pend_o (err_pend)
    );

    always_comb begin
        unique case (reg_addr_e'(addr_i))
            REG_CTRL:  rd_data_o = ctrl_rd;
            REG_ROUTE: rd_data_o = route_rd;
            REG_STAT:  rd_data_o = DATA_W'(status_vis);
            REG_ERR:   rd_data_o = DATA_W'(err_pend);
            default:   rd_data_o = '0;
        endcase
    end

    assign irq_master_o = master_en && (|status_vis);
    assign irq_err_o    = err_pend;

endmodule

// File: rtl/dma_irq_router_chk.sv
module dma_irq_router_chk #(
    parameter int NUM_CH  = 8,
    parameter int NUM_DED = 3,
    parameter int DATA_W  = 16
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic [NUM_CH-1:0]  done_i,
    input logic               err_i,
    input logic               wr_en_i,
    input logic [1:0]         addr_i,
    input logic [DATA_W-1:0]  wr_data_i,
    input logic               irq_master_o,
    input logic [NUM_DED-1:0] irq_ded_o,
    input logic               irq_err_o,
    input logic               master_en,
    input logic [NUM_DED-1:0] ded_en,
    input logic [NUM_CH-1:0]  status_vis
);
    assert_reset_quiet_R1: assert property (@(posedge clk_i)
        rst_i |=> (!irq_master_o && irq_ded_o == '0 && !irq_err_o && status_vis == '0));

    assert_master_gate_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_master_o |-> (master_en && status_vis != '0));

    assert_ded_from_done_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_ded_o != '0) |-> $past(done_i != '0));

    for (genvar k = 0; k < NUM_DED; k++) begin : g_line_chk
        assert_ded_enable_R7: assert property (@(posedge clk_i) disable iff (rst_i)
            irq_ded_o[k] |-> $past(ded_en[k]));
    end

    assert_err_set_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        err_i |=> irq_err_o);

    assert_err_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_err_o && !(wr_en_i && addr_i == 2'd3 && wr_data_i[0])) |=> irq_err_o);

endmodule

bind dma_irq_router dma_irq_router_chk #(
    .NUM_CH(NUM_CH), .NUM_DED(NUM_DED), .DATA_W(DATA_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .done_i       (done_i),
    .err_i        (err_i),
    .wr_en_i      (wr_en_i),
    .addr_i       (addr_i),
    .wr_data_i    (wr_data_i),
    .irq_master_o (irq_master_o),
    .irq_ded_o    (irq_ded_o),
    .irq_err_o    (irq_err_o),
    .master_en    (master_en),
    .ded_en       (ded_en),
    .status_vis   (status_vis)
);

// File: tb/sim_dma_irq_router.sv
module sim_dma_irq_router;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 8;
    localparam int NUM_DED    = 3;
    localparam int DATA_W     = 16;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NUM_CH-1:0]  done = '0;
    logic               err = 1'b0;
    logic               wr_en = 1'b0;
    logic [1:0]         addr = '0;
    logic [DATA_W-1:0]  wr_data = '0;
    logic [DATA_W-1:0]  rd_data;
    logic               irq_master;
    logic [NUM_DED-1:0] irq_ded;
    logic               irq_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_irq_router #(.NUM_CH(NUM_CH), .NUM_DED(NUM_DED), .DATA_W(DATA_W)) u0 (
        .clk_i(clk), .rst_i(rst), .done_i(done), .err_i(err), .wr_en_i(wr_en),
        .addr_i(addr), .wr_data_i(wr_data), .rd_data_o(rd_data),
        .irq_master_o(irq_master), .irq_ded_o(irq_ded), .irq_err_o(irq_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clock of stimulus, returning at the falling edge after the capturing edge.
    task automatic step(input logic [NUM_CH-1:0] d, input logic e, input logic w,
                        input logic [1:0] a, input logic [DATA_W-1:0] wd);
        @(negedge clk);
        done = d; err = e; wr_en = w; addr = a; wr_data = wd;
        @(negedge clk);
        done = '0; err = 1'b0; wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] wd);
        step('0, 1'b0, 1'b1, a, wd);
    endtask

    task automatic pulse(input logic [NUM_CH-1:0] d);
        step(d, 1'b0, 1'b0, 2'd0, '0);
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic t_reset();
        int v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1", $sformatf("reg %0d after reset", a), v, 0);
        end
        chk("R1", "outputs after reset", {irq_master, irq_ded, irq_err}, 0);
    endtask

    task automatic t_status();
        int v;
        wr(2'd0, 16'h0001);
        pulse(8'h08);
        rd(2'd2, v);
        chk("R2", "status after ch3 done", v, 'h08);
        chk("R3", "master irq with enable", irq_master, 1);
        pulse(8'h21);
        rd(2'd2, v);
        chk("R9", "status after ch0+ch5 together", v, 'h29);
        wr(2'd0, 16'h0000);
        chk("R3", "master irq with enable off", irq_master, 0);
        rd(2'd2, v);
        chk("R3", "status kept while disabled", v, 'h29);
        wr(2'd0, 16'h0001);
        chk("R3", "master irq re-enabled", irq_master, 1);
    endtask

    task automatic t_clear();
        int v;
        wr(2'd2, 16'h0008);
        rd(2'd2, v);
        chk("R4", "clear of ch3 only", v, 'h21);
        step(8'h02, 1'b0, 1'b1, 2'd2, 16'h0002);
        rd(2'd2, v);
        chk("R4", "done beats clear same cycle", v, 'h23);
        wr(2'd2, 16'h00FF);
        rd(2'd2, v);
        chk("R4", "clear all", v, 0);
        chk("R3", "master irq after clear all", irq_master, 0);
    endtask

    task automatic t_route();
        int v;
        // line0 -> ch6, line1 -> ch2, line2 -> ch7
        wr(2'd1, 16'(6 | (2 << 3) | (7 << 6)));
        rd(2'd1, v);
        chk("R5", "routing readback", v, 470);
        wr(2'd0, 16'h0003);
        pulse(8'h40);
        chk("R5", "line0 pulse on ch6", irq_ded, 3'b001);
        rd(2'd2, v);
        chk("R6", "steered ch6 not in status", v, 0);
        chk("R6", "master quiet for steered ch6", irq_master, 0);
        @(negedge clk);
        chk("R5", "pulse lasts one cycle", irq_ded, 3'b000);
        pulse(8'h04);
        chk("R7", "disabled line1 silent", irq_ded, 3'b000);
        rd(2'd2, v);
        chk("R7", "ch2 back on master path", v, 'h04);
        wr(2'd2, 16'h00FF);
        wr(2'd0, 16'h000F);
        pulse(8'h80);
        chk("R5", "line2 pulse on ch7", irq_ded, 3'b100);
        pulse(8'h44);
        chk("R5", "lines 0 and 1 together", irq_ded, 3'b011);
        rd(2'd2, v);
        chk("R6", "status empty after steered pulses", v, 0);
    endtask

    task automatic t_hidden();
        int v;
        wr(2'd0, 16'h0001);
        pulse(8'h40);
        rd(2'd2, v);
        chk("R2", "ch6 status unrouted", v, 'h40);
        wr(2'd0, 16'h0003);
        rd(2'd2, v);
        chk("R6", "held bit hidden when steered", v, 0);
        chk("R6", "master quiet while hidden", irq_master, 0);
        wr(2'd2, 16'h0040);
        wr(2'd0, 16'h0001);
        rd(2'd2, v);
        chk("R6", "clear ignored while steered", v, 'h40);
        chk("R3", "master irq after unsteer", irq_master, 1);
        wr(2'd2, 16'h00FF);
    endtask

    task automatic t_error();
        int v;
        step('0, 1'b1, 1'b0, 2'd0, '0);
        chk("R8", "error irq set", irq_err, 1);
        rd(2'd3, v);
        chk("R8", "error readback", v, 1);
        repeat (3) @(negedge clk);
        chk("R8", "error sticky", irq_err, 1);
        wr(2'd3, 16'h0001);
        chk("R8", "error cleared", irq_err, 0);
        step('0, 1'b1, 1'b1, 2'd3, 16'h0001);
        chk("R8", "error beats clear", irq_err, 1);
        wr(2'd3, 16'h0001);
        chk("R8", "error cleared again", irq_err, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_status();
        t_clear();
        t_route();
        t_hidden();
        t_error();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule